// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block turns a set of already-synchronized input signals into per-channel interrupt requests. Each channel is independently configured to be edge-triggered or level-triggered. In edge mode, rising and falling transitions are captured in sticky flags, and each flag has its own enable. In level mode, the channel requests whenever its input matches a programmable polarity, and the rising enable gates that request.

Software controls the block through a simple single-cycle register bus. The bus carries a write strobe, an address and write data. Read data is returned combinationally from the address.

- The two enable registers each have a plain read/write address, a set-by-ones address and a clear-by-ones address.
- The edge flags are cleared by writing ones.
- The status register reports which channels are requesting. Writing a one to a status bit does one of two things, depending on the channel's mode:
  - in edge mode, it clears both of that channel's edge flags;
  - in level mode, it flips that channel's polarity.

Top module: `pint_ctrl`

## Requirements
- R1: After reset every register reads 0 and every interrupt output is low.
- R2: The mode register at offset 0x00 holds one bit per channel. A 0 means edge-triggered and a 1 means level-triggered. It reads back what was written.
- R3: The rise/level enable register is at 0x04 and is read/write. Writing ones at 0x08 sets the matching bits of it. Writing ones at 0x0C clears the matching bits. Zero bits written to 0x08 or 0x0C leave it unchanged.
- R4: The fall/polarity register is at 0x10 and is read/write. Writing ones at 0x14 sets bits and writing ones at 0x18 clears bits. In level mode, a 1 in this register means active-high and a 0 means active-low.
- R5: A channel's rise flag (read at 0x1C) sets one clock after its input goes from 0 to 1, compared against the input value registered on the previous clock. The flag stays set until a 1 is written to its bit at 0x1C. Writing a 0 has no effect.
- R6: A channel's fall flag (read at 0x20) sets one clock after its input goes from 1 to 0. It is sticky and is cleared by writing a 1 at 0x20, in the same way as R5.
- R7: For an edge-mode channel, the request is (rise flag AND rise enable) OR (fall flag AND fall enable). The status register at 0x24 reads the current request vector, which equals `irq_out`.
- R8: For a level-mode channel, the request is the rise/level enable AND (input equals the polarity bit). The request follows the input with no register delay.
- R9: A 1 written to a status bit at 0x24 has a mode-dependent effect. For an edge-mode channel it clears both of that channel's flags. For a level-mode channel it inverts that channel's polarity bit. A 0 written to a status bit does nothing.
- R10: If an edge is detected in the same cycle that software clears the matching flag, the flag remains set.
- R11: Only the low 8 bits of each register exist, and the upper data bits read 0. The write-only alias addresses (0x08, 0x0C, 0x14, 0x18) and unmapped addresses all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | N | Synchronized channel inputs |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq_out | output | N | Per-channel interrupt requests |

## Verification
The bench builds the block with its default parameters: eight channels, 32-bit data and a 12-bit address. At this width every bit of each register can be reached, and the 24 unimplemented upper data bits are visible on reads, so a write of all ones exposes any leakage into them. Edge-mode and level-mode channels run together in the same scenarios, so the two branches of the status write are exercised side by side. The collision case drives an input edge in the same clock as a one-to-clear write of the same flag.

// File: rtl/pint_pkg.sv
package pint_pkg;

    localparam int OFS_MODE    = 'h00;
    localparam int OFS_ENR     = 'h04;
    localparam int OFS_ENR_SET = 'h08;
    localparam int OFS_ENR_CLR = 'h0C;
    localparam int OFS_ENF     = 'h10;
    localparam int OFS_ENF_SET = 'h14;
    localparam int OFS_ENF_CLR = 'h18;
    localparam int OFS_RISE    = 'h1C;
    localparam int OFS_FALL    = 'h20;
    localparam int OFS_STAT    = 'h24;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_ENR,
        SEL_ENR_SET,
        SEL_ENR_CLR,
        SEL_ENF,
        SEL_ENF_SET,
        SEL_ENF_CLR,
        SEL_RISE,
        SEL_FALL,
        SEL_STAT
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        case (a)
            OFS_MODE:    return SEL_MODE;
            OFS_ENR:     return SEL_ENR;
            OFS_ENR_SET: return SEL_ENR_SET;
            OFS_ENR_CLR: return SEL_ENR_CLR;
            OFS_ENF:     return SEL_ENF;
            OFS_ENF_SET: return SEL_ENF_SET;
            OFS_ENF_CLR: return SEL_ENF_CLR;
            OFS_RISE:    return SEL_RISE;
            OFS_FALL:    return SEL_FALL;
            OFS_STAT:    return SEL_STAT;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pint_edge_det.sv
module pint_edge_det #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] rise_ev,
    output logic [N-1:0] fall_ev
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_ch
        assign rise_ev[i] = pin_in[i] & ~prev_q[i];
        assign fall_ev[i] = ~pin_in[i] & prev_q[i];
    end

endmodule

// File: rtl/pint_flags.sv
module pint_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_ev,
    input  logic [N-1:0] fall_ev,
    input  logic [N-1:0] clr_rise,
    input  logic [N-1:0] clr_fall,
    output logic [N-1:0] rise_flag,
    output logic [N-1:0] fall_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_flag <= '0;
            fall_flag <= '0;
        end else begin
            rise_flag <= (rise_flag & ~clr_rise) | rise_ev;
            fall_flag <= (fall_flag & ~clr_fall) | fall_ev;
        end
    end

    // Flags never drop without a clear request (R5, R6)
    assert_rise_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise == '0) |=> (($past(rise_flag) & ~rise_flag) == '0));
    assert_fall_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fall == '0) |=> (($past(fall_flag) & ~fall_flag) == '0));

    // A detected edge always lands in the flag, even against a clear (R10)
    assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (rise_ev | fall_ev) != '0) |=>
            (((rise_flag & $past(rise_ev)) == $past(rise_ev)) &&
             ((fall_flag & $past(fall_ev)) == $past(fall_ev))));

endmodule

// File: rtl/pint_cfg_regs.sv
module pint_cfg_regs
    import pint_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  reg_sel_e     sel,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mode,
    output logic [N-1:0] en_rise,
    output logic [N-1:0] en_fall
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= '0;
            en_rise <= '0;
            en_fall <= '0;
        end else if (wr) begin
            case (sel)
                SEL_MODE:    mode    <= wdata;
                SEL_ENR:     en_rise <= wdata;
                SEL_ENR_SET: en_rise <= en_rise | wdata;
                SEL_ENR_CLR: en_rise <= en_rise & ~wdata;
                SEL_ENF:     en_fall <= wdata;
                SEL_ENF_SET: en_fall <= en_fall | wdata;
                SEL_ENF_CLR: en_fall <= en_fall & ~wdata;
                SEL_STAT:    en_fall <= en_fall ^ (wdata & mode);
                default:     ;
            endcase
        end
    end

    assert_enr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr && sel == SEL_ENR_SET) |=>
            (((en_rise & $past(wdata)) == $past(wdata)) &&
             ((en_rise & ~$past(wdata)) == ($past(en_rise) & ~$past(wdata)))));
    assert_enr_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr && sel == SEL_ENR_CLR) |=>
            (((en_rise & $past(wdata)) == '0) &&
             ((en_rise & ~$past(wdata)) == ($past(en_rise) & ~$past(wdata)))));
    assert_enf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr && sel == SEL_ENF_SET) |=>
            ((en_fall & $past(wdata)) == $past(wdata)));
    assert_level_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr && sel == SEL_STAT) |=>
            ((en_fall ^ $past(en_fall)) == ($past(wdata) & $past(mode))));

endmodule

// File: rtl/pint_ctrl.sv
module pint_ctrl
    import pint_pkg::*;
#(
    parameter int N      = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N-1:0]      irq_out
);

    localparam int PAD_W = DATA_W - N;

    reg_sel_e     sel;
    logic [N-1:0] wd;
    logic [N-1:0] mode, en_rise, en_fall;
    logic [N-1:0] rise_ev, fall_ev, rise_flag, fall_flag;
    logic [N-1:0] clr_rise, clr_fall, stat_edge_clr;
    logic [N-1:0] rd_word;
    logic         unused_hi;

    assign sel       = decode_addr(32'(bus_addr));
    assign wd        = bus_wdata[N-1:0];
    assign unused_hi = ^bus_wdata[DATA_W-1:N];

    pint_cfg_regs #(.N(N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel), .wdata(wd),
        .mode(mode), .en_rise(en_rise), .en_fall(en_fall)
    );

    pint_edge_det #(.N(N)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    assign stat_edge_clr = (bus_wr && sel == SEL_STAT) ? (wd & ~mode) : '0;
    assign clr_rise = ((bus_wr && sel == SEL_RISE) ? wd : '0) | stat_edge_clr;
    assign clr_fall = ((bus_wr && sel == SEL_FALL) ? wd : '0) | stat_edge_clr;

    pint_flags #(.N(N)) u_flags (
        .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .fall_ev(fall_ev),
        .clr_rise(clr_rise), .clr_fall(clr_fall),
        .rise_flag(rise_flag), .fall_flag(fall_flag)
    );

    for (genvar i = 0; i < N; i++) begin : g_req
        assign irq_out[i] = mode[i]
            ? (en_rise[i] & ~(pin_in[i] ^ en_fall[i]))
            : ((rise_flag[i] & en_rise[i]) | (fall_flag[i] & en_fall[i]));
    end

    always_comb begin
        case (sel)
            SEL_MODE: rd_word = mode;
            SEL_ENR:  rd_word = en_rise;
            SEL_ENF:  rd_word = en_fall;
            SEL_RISE: rd_word = rise_flag;
            SEL_FALL: rd_word = fall_flag;
            SEL_STAT: rd_word = irq_out;
            default:  rd_word = '0;
        endcase
    end

    assign bus_rdata = {{PAD_W{1'b0}}, rd_word};

    assert_alias_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_ENR_SET || sel == SEL_ENR_CLR ||
         sel == SEL_ENF_SET || sel == SEL_ENF_CLR || sel == SEL_NONE) |-> (bus_rdata == '0));
    assert_status_edge_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && bus_wr && sel == SEL_STAT && (wd & ~mode & ~rise_ev) != '0) |=>
            ((rise_flag & $past(wd & ~mode & ~rise_ev)) == '0));

endmodule

// File: tb/tb_pint_ctrl.sv
`timescale 1ns/1ps
module tb_pint_ctrl;

    localparam int N = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      pin_in = '0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [N-1:0]      irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pint_ctrl #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic irq_chk(input string req, input logic [N-1:0] exp);
        @(negedge clk);
        #1 chk(req, 32'(irq_out), 32'(exp));
    endtask

    task automatic t_reset;
        rd_chk("R1 mode", 'h00, 0);
        rd_chk("R1 enr", 'h04, 0);
        rd_chk("R1 enf", 'h10, 0);
        rd_chk("R1 rise", 'h1C, 0);
        rd_chk("R1 fall", 'h20, 0);
        rd_chk("R1 stat", 'h24, 0);
        irq_chk("R1 irq", 8'h00);
    endtask

    task automatic t_mode;
        wr('h00, 32'hFFFF_FFA5);
        rd_chk("R2 mode rw", 'h00, 32'h0000_00A5);
        wr('h00, 0);
        rd_chk("R2 mode zero", 'h00, 0);
    endtask

    task automatic t_enr_aliases;
        wr('h04, 32'h0F);
        wr('h08, 32'h30);
        rd_chk("R3 set alias", 'h04, 32'h3F);
        wr('h0C, 32'h03);
        rd_chk("R3 clear alias", 'h04, 32'h3C);
        wr('h08, 0);
        wr('h0C, 0);
        rd_chk("R3 zero writes no effect", 'h04, 32'h3C);
        wr('h04, 0);
    endtask

    task automatic t_enf_aliases;
        wr('h10, 32'h81);
        wr('h14, 32'h06);
        rd_chk("R4 set alias", 'h10, 32'h87);
        wr('h18, 32'h81);
        rd_chk("R4 clear alias", 'h10, 32'h06);
        wr('h10, 0);
    endtask

    task automatic t_edge_flags;
        set_pins(8'h01);
        rd_chk("R5 rise flag set", 'h1C, 32'h01);
        rd_chk("R6 no fall yet", 'h20, 0);
        set_pins(8'h00);
        rd_chk("R6 fall flag set", 'h20, 32'h01);
        wr('h1C, 0);
        rd_chk("R5 write zero keeps flag", 'h1C, 32'h01);
        wr('h1C, 32'h01);
        rd_chk("R5 w1c rise", 'h1C, 0);
        rd_chk("R6 fall untouched", 'h20, 32'h01);
        wr('h20, 32'h01);
        rd_chk("R6 w1c fall", 'h20, 0);
    endtask

    task automatic t_edge_irq;
        wr('h04, 32'h02);
        wr('h10, 32'h04);
        set_pins(8'h06);
        irq_chk("R7 rise enabled only", 8'h02);
        set_pins(8'h00);
        irq_chk("R7 rise or fall", 8'h06);
        rd_chk("R7 status read", 'h24, 32'h06);
        wr('h24, 32'h02);
        rd_chk("R9 edge status clears rise", 'h1C, 32'h04);
        rd_chk("R9 edge status clears fall", 'h20, 32'h04);
        irq_chk("R9 irq after clear", 8'h04);
        wr('h24, 32'hFF);
        irq_chk("R9 all cleared", 8'h00);
        rd_chk("R9 enf untouched in edge mode", 'h10, 32'h04);
    endtask

    task automatic t_collision;
        set_pins(8'h01);
        set_pins(8'h00);
        @(negedge clk);
        pin_in = 8'h01;
        bus_wr = 1'b1; bus_addr = ADDR_W'('h1C); bus_wdata = 32'h01;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd_chk("R10 edge beats clear", 'h1C, 32'h01);
        wr('h1C, 32'h01);
        rd_chk("R10 later clear works", 'h1C, 0);
        set_pins(8'h00);
        wr('h20, 32'hFF);
    endtask

    task automatic t_level;
        wr('h00, 32'h10);
        wr('h04, 32'h10);
        wr('h10, 0);
        irq_chk("R8 active low asserted", 8'h10);
        set_pins(8'h10);
        #1 chk("R8 follows input same cycle", 32'(irq_out), 0);
        wr('h24, 0);
        rd_chk("R9 zero status write no effect", 'h10, 0);
        wr('h24, 32'h10);
        rd_chk("R9 level toggles polarity", 'h10, 32'h10);
        irq_chk("R8 active high asserted", 8'h10);
        rd_chk("R7 status matches level", 'h24, 32'h10);
        set_pins(8'h00);
        irq_chk("R8 active high idle", 8'h00);
        wr('h0C, 32'h10);
        set_pins(8'h10);
        irq_chk("R8 disabled level", 8'h00);
    endtask

    task automatic t_reserved;
        wr('h04, 32'hFFFF_FFFF);
        rd_chk("R11 upper bits zero", 'h04, 32'h0000_00FF);
        rd_chk("R11 set alias reads zero", 'h08, 0);
        rd_chk("R11 clear alias reads zero", 'h0C, 0);
        rd_chk("R11 fall set alias reads zero", 'h14, 0);
        rd_chk("R11 fall clear alias reads zero", 'h18, 0);
        rd_chk("R11 unmapped reads zero", 'h28, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode();
        t_enr_aliases();
        t_enf_aliases();
        t_edge_flags();
        t_edge_irq();
        t_collision();
        t_level();
        t_reserved();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule